// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This block holds two independent 8-bit down-counting timers. Each timer is paced by its own 6-bit programmable prescaler. Software loads a prescale value and an initial count through a small register-style bus. It then issues per-timer commands: stop, resume from the held count, or reload from the initial value and run. Each timer runs either once (single-pass) or repeatedly (auto-reload). At every end of count it raises a one-cycle interrupt pulse. The current count of each timer can be read at any moment. The prescalers cannot be read.

Timer 0 is always paced by an internal tick, which is the block clock divided by `INT_DIV`. Timer 1 takes its count pulses from one of three sources: the internal tick, a synchronous external pulse input, or the end-of-count events of timer 0. The third choice chains the two timers into one long counter. A square-wave output toggles on every end of count of timer 1.

The register map is as follows. Address 0 writes the timer 0 prescale value, and address 2 writes the timer 1 prescale value; both read back as zero. Address 1 writes the timer 0 initial value and reads its current count. Address 3 does the same for timer 1. Address 4 is the control register, and its read layout is given in R12.

Top module: `dual_timer`

## Requirements
- R1: While reset is asserted, and after it is released, both interrupt outputs and `tmr_out` are 0, both counts read 0, and the control read is 0.
- R2: A prescale value P in 1..63 produces one counter step per P source pulses. P = 0 produces one step per 64 source pulses.
- R3: An initial value N in 1..255 gives an end of count after N counter steps. N = 0 gives a period of 256 steps.
- R4: Each end of count of timer 0 makes `irq_t0` high for exactly the next cycle. Each end of count of timer 1 does the same for `irq_t1`.
- R5: In single-pass mode (control bit 4 for timer 0, bit 5 for timer 1 set to 0), the timer stops at end of count and its count reads 0.
- R6: In auto-reload mode (the mode bit set to 1), the count is reloaded from the initial value at end of count and counting goes on.
- R7: Command 01 stops a timer and its count holds. Command 10 resumes counting from the held count and the held prescaler phase. Timer 0's command is in control bits [1:0]; timer 1's is in bits [3:2]; 00 means no command.
- R8: Command 11 loads the count from the initial value and the prescaler from the prescale value, then runs. It takes precedence over a count step in the same cycle.
- R9: Reading any register has no effect on any count, mode or output.
- R10: Timer 0 receives one source pulse every `INT_DIV` clock cycles.
- R11: Control bits [7:6] select the timer 1 source: 00 selects the internal tick, 01 selects `ext_tick`, and 10 selects timer 0 end-of-count events. The value 11 acts as 00.
- R12: `tmr_out` toggles once for each end of count of timer 1, in the same cycle that `irq_t1` is high. The control read returns {source[1:0], mode1, mode0, 2'b00, running1, running0}.
- R13: Writing a prescale or initial value while a timer runs does not change its current count. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_tick | input | 1 | Synchronous external count pulse for timer 1 |
| irq_t0 | output | 1 | Timer 0 end-of-count pulse |
| irq_t1 | output | 1 | Timer 1 end-of-count pulse |
| tmr_out | output | 1 | Square wave toggled by timer 1 end of count |

## Verification
A write or command is captured at the clock edge where `bus_we` is seen. The read data reflect it from the following cycle. A count step occurs at the edge where a source pulse completes a prescale period. The interrupt and `tmr_out` change one edge after that step, because they are registered. The cascade adds no cycle, since timer 0's end of count feeds timer 1 within the same cycle. The bench reference model advances on each rising edge with these same delays. It is compared at the following falling edge, when inputs are quiet. Directed interval measurements between interrupt pulses confirm the divide ratios independently of the per-cycle model.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_STOP   = 2'b01,
    CMD_RESUME = 2'b10,
    CMD_RELOAD = 2'b11
  } tmr_cmd_e;

  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_EXT  = 2'b01,
    SRC_CASC = 2'b10,
    SRC_RSVD = 2'b11
  } tmr_src_e;

  localparam logic [2:0] A_PRE0  = 3'd0;
  localparam logic [2:0] A_INIT0 = 3'd1;
  localparam logic [2:0] A_PRE1  = 3'd2;
  localparam logic [2:0] A_INIT1 = 3'd3;
  localparam logic [2:0] A_CTRL  = 3'd4;
endpackage

// File: rtl/dt_tick_gen.sv
module dt_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: internal pulses are never back to back
  p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dt_channel.sv
module dt_channel
  import dt_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_pulse,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [CNT_W-1:0] init_val,
  input  tmr_cmd_e         cmd,
  input  logic             cont_mode,
  output logic             eoc,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  logic             run_q, run_d;
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step, tick, upd_en;

  always_comb begin
    step   = run_q && src_pulse && (cmd == CMD_NONE);
    tick   = step && (pcnt_q == PRE_W'(1));
    eoc    = tick && (cnt_q == CNT_W'(1));
    upd_en = step || (cmd != CMD_NONE);
    run_d  = run_q;
    pcnt_d = pcnt_q;
    cnt_d  = cnt_q;
    case (cmd)
      CMD_STOP:   run_d = 1'b0;
      CMD_RESUME: run_d = 1'b1;
      CMD_RELOAD: begin
        run_d  = 1'b1;
        pcnt_d = pre_val;
        cnt_d  = init_val;
      end
      default: begin
        if (step) begin
          pcnt_d = tick ? pre_val : pcnt_q - PRE_W'(1);
          if (eoc) begin
            cnt_d = cont_mode ? init_val : '0;
            run_d = cont_mode;
          end else if (tick) begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      run_q  <= run_d;
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign count   = cnt_q;
  assign running = run_q;

  // R7: a stopped timer holds its count
  p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && cmd == CMD_NONE) |=> $stable(cnt_q));
  // R5: single-pass ends stopped at zero
  p_single_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !cont_mode) |=> (!run_q && cnt_q == '0));
  // R6: auto-reload restores the initial value and keeps running
  p_cont_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && cont_mode) |=> (run_q && cnt_q == $past(init_val)));
  // R8: reload command loads the initial value and runs
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RELOAD) |=> (run_q && cnt_q == $past(init_val)));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dt_pkg::*;
#(
  parameter int INT_DIV = 4,
  parameter int PRE_W   = 6,
  parameter int CNT_W   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_tick,
  output logic       irq_t0,
  output logic       irq_t1,
  output logic       tmr_out
);
  localparam int NT = 2;

  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic [NT-1:0][PRE_W-1:0] pre_q, pre_d;
  logic [NT-1:0][CNT_W-1:0] init_q, init_d, cnt;
  logic [NT-1:0]            cont_q, cont_d, eoc, run, src_p;
  tmr_src_e                 src_q, src_d;
  tmr_cmd_e                 cmd [NT];
  logic                     ctrl_wr, int_tick;
  logic [NT-1:0]            irq_q;
  logic                     tout_q;

  dt_tick_gen #(.DIV(INT_DIV)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .tick(int_tick)
  );

  always_comb begin
    ctrl_wr = bus_we && (bus_addr == A_CTRL);
    pre_d   = pre_q;
    init_d  = init_q;
    cont_d  = cont_q;
    src_d   = src_q;
    if (bus_we) begin
      case (bus_addr)
        A_PRE0:  pre_d[0]  = bus_wdata[PRE_W-1:0];
        A_INIT0: init_d[0] = bus_wdata[CNT_W-1:0];
        A_PRE1:  pre_d[1]  = bus_wdata[PRE_W-1:0];
        A_INIT1: init_d[1] = bus_wdata[CNT_W-1:0];
        A_CTRL: begin
          cont_d = bus_wdata[5:4];
          src_d  = tmr_src_e'(bus_wdata[7:6]);
        end
        default: ;
      endcase
    end
    cmd[0] = ctrl_wr ? tmr_cmd_e'(bus_wdata[1:0]) : CMD_NONE;
    cmd[1] = ctrl_wr ? tmr_cmd_e'(bus_wdata[3:2]) : CMD_NONE;
    src_p[0] = int_tick;
    case (src_q)
      SRC_EXT:  src_p[1] = ext_tick;
      SRC_CASC: src_p[1] = eoc[0];
      default:  src_p[1] = int_tick;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pre_q  <= '0;
      init_q <= '0;
      cont_q <= '0;
      src_q  <= SRC_INT;
    end else if (bus_we) begin
      pre_q  <= pre_d;
      init_q <= init_d;
      cont_q <= cont_d;
      src_q  <= src_d;
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_ch
    dt_channel #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_s_n), .src_pulse(src_p[i]),
      .pre_val(pre_q[i]), .init_val(init_q[i]), .cmd(cmd[i]),
      .cont_mode(cont_q[i]), .eoc(eoc[i]), .count(cnt[i]), .running(run[i])
    );
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_q  <= '0;
      tout_q <= 1'b0;
    end else begin
      irq_q  <= eoc;
      tout_q <= tout_q ^ eoc[1];
    end
  end

  always_comb begin
    case (bus_addr)
      A_INIT0: bus_rdata = 8'(cnt[0]);
      A_INIT1: bus_rdata = 8'(cnt[1]);
      A_CTRL:  bus_rdata = {src_q, cont_q[1], cont_q[0], 2'b00, run[1], run[0]};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_t0  = irq_q[0];
  assign irq_t1  = irq_q[1];
  assign tmr_out = tout_q;

  // R12: the square wave flips exactly when timer 1 signals end of count
  p_tout_toggle_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_t1 |-> (tmr_out != $past(tmr_out)));
  p_tout_hold_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    !irq_t1 |-> (tmr_out == $past(tmr_out)));
  // R4: interrupt follows an end of count by one cycle
  p_irq0_follow_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    eoc[0] |=> irq_t0);
endmodule

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_tick = 1'b0;
  logic       irq_t0, irq_t1, tmr_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dual_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
    .irq_t0(irq_t0), .irq_t1(irq_t1), .tmr_out(tmr_out)
  );

  // behavioural reference: remaining pulses / steps as integers
  int prem[2], crem[2], pre[2], init[2];
  bit run[2], cont[2];
  int src, divc, rs;
  bit m_irq[2];
  bit m_tout;

  task automatic chan(input int i, input bit pulse, input int c, output bit e);
    e = 0;
    if (c == 1) run[i] = 0;
    else if (c == 2) run[i] = 1;
    else if (c == 3) begin
      run[i] = 1;
      prem[i] = (pre[i] == 0) ? 64 : pre[i];
      crem[i] = (init[i] == 0) ? 256 : init[i];
    end else if (run[i] && pulse) begin
      if (prem[i] == 1) begin
        prem[i] = (pre[i] == 0) ? 64 : pre[i];
        if (crem[i] == 1) begin
          e = 1;
          if (cont[i]) crem[i] = (init[i] == 0) ? 256 : init[i];
          else begin crem[i] = 256; run[i] = 0; end
        end else crem[i]--;
      end else prem[i]--;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        prem[i] = 64; crem[i] = 256; pre[i] = 0; init[i] = 0;
        run[i] = 0; cont[i] = 0; m_irq[i] = 0;
      end
      src = 0; divc = 0; rs = 0; m_tout = 0;
    end else if (rs < 2) begin
      rs++;
    end else begin
      bit ip, e0, e1, sp1;
      int c0, c1;
      ip = (divc == 3);
      divc = (divc + 1) % 4;
      c0 = (bus_we && bus_addr == 3'd4) ? int'(bus_wdata[1:0]) : 0;
      c1 = (bus_we && bus_addr == 3'd4) ? int'(bus_wdata[3:2]) : 0;
      chan(0, ip, c0, e0);
      sp1 = (src == 1) ? ext_tick : (src == 2) ? e0 : ip;
      chan(1, sp1, c1, e1);
      m_irq[0] = e0; m_irq[1] = e1;
      if (e1) m_tout = ~m_tout;
      if (bus_we) begin
        case (bus_addr)
          3'd0: pre[0] = int'(bus_wdata[5:0]);
          3'd1: init[0] = int'(bus_wdata);
          3'd2: pre[1] = int'(bus_wdata[5:0]);
          3'd3: init[1] = int'(bus_wdata);
          3'd4: begin cont[0] = bus_wdata[4]; cont[1] = bus_wdata[5]; src = int'(bus_wdata[7:6]); end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd1: return 8'(crem[0] % 256);
      3'd3: return 8'(crem[1] % 256);
      3'd4: return {2'(src), cont[1], cont[0], 2'b00, run[1], run[0]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    chk(cur_req, "irq_t0", int'(irq_t0), int'(m_irq[0]));
    chk(cur_req, "irq_t1", int'(irq_t1), int'(m_irq[1]));
    chk(cur_req, "tmr_out", int'(tmr_out), int'(m_tout));
    chk(cur_req, "rdata", int'(bus_rdata), int'(m_read(bus_addr)));
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n, input logic [2:0] ra);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      bus_addr = ra;
    end
  endtask

  // cycles between two successive rising interrupt pulses
  task automatic meas(input int which, output int n);
    int guard;
    n = 0; guard = 0;
    do begin @(negedge clk); guard++; end
    while (((which == 0) ? irq_t0 : irq_t1) !== 1'b1 && guard < 2000);
    do begin @(negedge clk); n++; end
    while (((which == 0) ? irq_t0 : irq_t1) !== 1'b1 && n < 2000);
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete");
    report();
  end

  initial begin
    int n;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk("R1", "irq_t0 in reset", int'(irq_t0), 0);
    chk("R1", "tmr_out in reset", int'(tmr_out), 0);
    #1 rst_n = 1'b1;
    idle(5, 3'd4);
    chk("R1", "ctrl after reset", int'(bus_rdata), 0);
    bus_addr = 3'd1; #0.5;
    chk("R1", "count0 after reset", int'(bus_rdata), 0);

    // R2 R3 R6: timer 0 auto-reload, prescale 2, initial 3
    cur_req = "R6";
    wr(3'd0, 8'd2); wr(3'd1, 8'd3);
    wr(3'd4, 8'b0001_0011);
    idle(3, 3'd1);
    meas(0, n);
    chk("R2", "t0 period pre2 init3", n, 24);

    // R9 R7: reads during run, stop holds, resume continues
    cur_req = "R9";
    idle(40, 3'd1);
    cur_req = "R7";
    wr(3'd4, 8'b0001_0001);
    idle(2, 3'd1);
    held = bus_rdata;
    idle(30, 3'd1);
    chk("R7", "count held while stopped", int'(bus_rdata), int'(held));
    wr(3'd4, 8'b0001_0010);
    idle(40, 3'd1);

    // R13: new initial value while running does not move the count
    cur_req = "R13";
    wr(3'd1, 8'd5);
    idle(60, 3'd1);
    meas(0, n);
    chk("R13", "period after new init", n, 40);

    // R2 R3: prescale 0 means 64, then single-pass R5
    cur_req = "R2";
    wr(3'd0, 8'd0); wr(3'd1, 8'd1);
    wr(3'd4, 8'b0001_0011);
    meas(0, n);
    chk("R2", "prescale 0 acts as 64", n, 256);
    cur_req = "R5";
    wr(3'd4, 8'b0000_0011);
    idle(300, 3'd1);
    chk("R5", "single-pass count", int'(bus_rdata), 0);
    bus_addr = 3'd4; #0.5;
    chk("R5", "single-pass stopped", int'(bus_rdata[0]), 0);

    // R11 R3 R12: timer 1 on external pulses, init 0 = 256
    cur_req = "R11";
    wr(3'd2, 8'd1); wr(3'd3, 8'd0);
    wr(3'd4, 8'b0110_1100);
    ext_tick = 1'b1;
    meas(1, n);
    chk("R3", "init 0 gives 256 steps", n, 256);
    cur_req = "R12";
    for (int k = 0; k < 700; k++) begin
      @(negedge clk); #1;
      ext_tick = (k % 3) != 0;
      bus_addr = 3'd3;
    end
    ext_tick = 1'b0;
    idle(20, 3'd3);
    chk("R11", "external source halted", int'(irq_t1), 0);

    // R11 R4 R8: cascade timer 0 into timer 1
    cur_req = "R8";
    wr(3'd0, 8'd1); wr(3'd1, 8'd2); wr(3'd3, 8'd3);
    wr(3'd4, 8'b1011_1111);
    cur_req = "R4";
    meas(1, n);
    chk("R11", "cascade period", n, 24);
    meas(0, n);
    chk("R10", "t0 period at internal rate", n, 8);
    idle(100, 3'd3);
    // R11: reserved selector acts as internal
    cur_req = "R11";
    wr(3'd4, 8'b1111_1111);
    idle(200, 3'd3);
    report();
  end
endmodule